// File: doc/BRIEF.md
# Burst Upsizer Command Translator

This block sits on one address channel (read or write) between a narrow slave-side port and a wider master-side port. For every accepted command it decides whether the burst can be packed into wide beats. If it can, it rewrites the length, the start address, the transfer size and the burst type for the wide side. If it cannot, it forwards the command untouched. The data-path packing and unpacking logic and the strobe logic sit outside this block.

Next to the translated command, the block hands the data path three pieces of side information:
- the size the slave side asked for;
- the low address bits that select a lane inside one wide beat;
- a flag that says whether the command was packed.

The result goes through one registered stage with valid/ready handshakes on both sides.

Slave and master data widths are parameters between 32 and 1024 bits, and the master width must be the larger of the two. A parameter selects the write-channel variant or the read-channel variant, because the two round the start address of a wrapping burst differently. A second parameter marks the port as a single-beat lite protocol. Such a port never packs.

Top module: `upsz_cmd_xlate`

## Requirements
- R1: With cache bit 1 clear, the output address, length, size, burst, lock and cache equal the input, and the packed flag is 0.
- R2: Burst encoding is 0 = FIXED, 1 = INCR, 2 = WRAP, 3 = reserved. FIXED and reserved bursts pass through unchanged with packed flag 0, whatever the cache value.
- R3: When the lite parameter is set, every command passes through unchanged with packed flag 0.
- R4: A packable INCR keeps its address and burst. Its length becomes (E - S) / MB, where MB is the master byte count, S = addr rounded down to MB, and E = ((addr rounded down to 2^size) + len*2^size) rounded down to MB. Its size becomes log2(MB).
- R5: A packable WRAP gets length ceil((len+1)*2^size / MB) - 1 and size log2(MB). Its burst stays WRAP when that length is nonzero and becomes INCR when it is zero.
- R6: On the write variant, a packable WRAP starts at W + (ceil(O / MB)*MB mod B). Here B = (len+1)*2^size, W = addr rounded down to B, and O = addr - W.
- R7: On the read variant, a packable WRAP starts at W + floor(O / MB)*MB, using the same B, W and O as R6.
- R8: The output lock bit always equals the input lock bit.
- R9: The side outputs carry the input size, the input address modulo MB, and the packed flag. The flag is 1 exactly when the command was packed.
- R10: An accepted command appears on the output with valid high on the next cycle. s_ready is low while a held result is not taken. The held result stays stable until m_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Slave-side command valid |
| s_ready | output | 1 | Slave-side command ready |
| s_addr | input | AW | Command byte address |
| s_len | input | 8 | Beats minus one |
| s_size | input | 3 | log2 of bytes per beat |
| s_burst | input | 2 | Burst type |
| s_lock | input | 1 | Lock attribute |
| s_cache | input | 4 | Cache attributes; bit 1 marks modifiable |
| m_valid | output | 1 | Master-side command valid |
| m_ready | input | 1 | Master-side command ready |
| m_addr | output | AW | Translated address |
| m_len | output | 8 | Translated length |
| m_size | output | 3 | Translated size |
| m_burst | output | 2 | Translated burst type |
| m_lock | output | 1 | Lock attribute |
| m_cache | output | 4 | Cache attributes |
| m_packed | output | 1 | Command was packed |
| m_orig_size | output | 3 | Slave-side size |
| m_low_addr | output | log2(M_DW/8) | Address bits inside one wide beat |

## Verification
Every legal size is swept against 64 consecutive start addresses, every burst type, several lengths and two cache values. The cache values are one with bit 1 set and one with bit 1 clear but other bits set, so a decision taken on the wrong cache bit shows up. The same stimulus goes to a write instance, a read instance and a lite instance at once. Unaligned offsets inside a wrap window then separate the round-up start from the round-down start. Short wraps that fit in one wide beat separate the WRAP-to-INCR collapse from the kept-WRAP case. A stall sequence holds m_ready low while a second command waits, to show that the held result stays put and s_ready stays low.

// File: rtl/upsz_pkg.sv
package upsz_pkg;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;
    localparam int CACHE_W = 4;

    typedef enum logic [BURST_W-1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_e;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [SIZE_W-1:0]  size;
        burst_e             burst;
        logic               lock;
        logic [CACHE_W-1:0] cache;
    } ctl_t;

    function automatic logic is_packable_burst(input logic [BURST_W-1:0] b);
        return (b == BT_INCR) || (b == BT_WRAP);
    endfunction
endpackage

// File: rtl/upsz_classify.sv
module upsz_classify import upsz_pkg::*; #(
    parameter int LITE = 0
) (
    input  logic [BURST_W-1:0] burst,
    input  logic               modifiable,
    output logic               packable
);
    generate
        if (LITE != 0) begin : g_lite
            assign packable = 1'b0;
        end else begin : g_full
            assign packable = modifiable & is_packable_burst(burst);
        end
    endgenerate
endmodule

// File: rtl/upsz_incr_calc.sv
module upsz_incr_calc import upsz_pkg::*; #(
    parameter int AW   = 32,
    parameter int MLOG = 4
) (
    input  logic [AW-1:0]     addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [LEN_W-1:0]  o_len
);
    localparam logic [AW-1:0] MMASK = AW'((1 << MLOG) - 1);

    logic [AW-1:0] size_mask;
    logic [AW-1:0] first_wide;
    logic [AW-1:0] last_wide;

    always_comb begin
        size_mask  = (AW'(1) << size) - AW'(1);
        first_wide = addr & ~MMASK;
        last_wide  = ((addr & ~size_mask) + (AW'(len) << size)) & ~MMASK;
        o_len      = LEN_W'((last_wide - first_wide) >> MLOG);
    end
endmodule

// File: rtl/upsz_wrap_calc.sv
module upsz_wrap_calc import upsz_pkg::*; #(
    parameter int AW       = 32,
    parameter int MLOG     = 4,
    parameter int IS_WRITE = 1
) (
    input  logic [AW-1:0]     addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [LEN_W-1:0]  o_len,
    output logic [AW-1:0]     o_addr,
    output burst_e            o_burst
);
    localparam logic [AW-1:0] MMASK = AW'((1 << MLOG) - 1);

    logic [AW-1:0] win_bytes;
    logic [AW-1:0] win_mask;
    logic [AW-1:0] win_base;
    logic [AW-1:0] win_off;
    logic [AW-1:0] start_off;

    always_comb begin
        win_bytes = (AW'(len) + AW'(1)) << size;
        win_mask  = win_bytes - AW'(1);
        win_base  = addr & ~win_mask;
        win_off   = addr & win_mask;
        o_len     = LEN_W'(((win_bytes + MMASK) >> MLOG) - AW'(1));
        o_burst   = (o_len != '0) ? BT_WRAP : BT_INCR;
        o_addr    = win_base | start_off;
    end

    generate
        if (IS_WRITE != 0) begin : g_round_up
            assign start_off = ((win_off + MMASK) & ~MMASK) & win_mask;
        end else begin : g_round_down
            assign start_off = win_off & ~MMASK;
        end
    endgenerate
endmodule

// File: rtl/upsz_out_slice.sv
module upsz_out_slice #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    // R10: a stalled result holds its contents
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R10: an accepted command is presented the next cycle
    assert_accept_visible_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));
endmodule

// File: rtl/upsz_cmd_xlate.sv
module upsz_cmd_xlate import upsz_pkg::*; #(
    parameter int S_DW     = 32,
    parameter int M_DW     = 128,
    parameter int AW       = 32,
    parameter int IS_WRITE = 1,
    parameter int LITE     = 0,
    localparam int M_BYTES = M_DW / 8,
    localparam int MLOG    = $clog2(M_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [AW-1:0]      s_addr,
    input  logic [LEN_W-1:0]   s_len,
    input  logic [SIZE_W-1:0]  s_size,
    input  logic [BURST_W-1:0] s_burst,
    input  logic               s_lock,
    input  logic [CACHE_W-1:0] s_cache,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [AW-1:0]      m_addr,
    output logic [LEN_W-1:0]   m_len,
    output logic [SIZE_W-1:0]  m_size,
    output logic [BURST_W-1:0] m_burst,
    output logic               m_lock,
    output logic [CACHE_W-1:0] m_cache,
    output logic               m_packed,
    output logic [SIZE_W-1:0]  m_orig_size,
    output logic [MLOG-1:0]    m_low_addr
);
    localparam int SLOG = $clog2(S_DW / 8);

    typedef struct packed {
        logic [AW-1:0]     addr;
        ctl_t              ctl;
        logic              pk;
        logic [SIZE_W-1:0] osize;
        logic [MLOG-1:0]   low;
    } out_t;

    initial assert (MLOG > SLOG) else $error("master width must exceed slave width");

    logic             packable;
    logic [LEN_W-1:0] incr_len;
    logic [LEN_W-1:0] wrap_len;
    logic [AW-1:0]    wrap_addr;
    burst_e           wrap_burst;
    out_t             nxt;
    out_t             q;

    upsz_classify #(.LITE(LITE)) u_cls (
        .burst      (s_burst),
        .modifiable (s_cache[1]),
        .packable   (packable)
    );

    upsz_incr_calc #(.AW(AW), .MLOG(MLOG)) u_incr (
        .addr  (s_addr),
        .len   (s_len),
        .size  (s_size),
        .o_len (incr_len)
    );

    upsz_wrap_calc #(.AW(AW), .MLOG(MLOG), .IS_WRITE(IS_WRITE)) u_wrap (
        .addr    (s_addr),
        .len     (s_len),
        .size    (s_size),
        .o_len   (wrap_len),
        .o_addr  (wrap_addr),
        .o_burst (wrap_burst)
    );

    always_comb begin
        nxt.addr      = s_addr;
        nxt.ctl.len   = s_len;
        nxt.ctl.size  = s_size;
        nxt.ctl.burst = burst_e'(s_burst);
        nxt.ctl.lock  = s_lock;
        nxt.ctl.cache = s_cache;
        nxt.pk        = packable;
        nxt.osize     = s_size;
        nxt.low       = s_addr[MLOG-1:0];
        if (packable) begin
            nxt.ctl.size = SIZE_W'(MLOG);
            if (s_burst == BT_INCR) begin
                nxt.ctl.len = incr_len;
            end else begin
                nxt.ctl.len   = wrap_len;
                nxt.addr      = wrap_addr;
                nxt.ctl.burst = wrap_burst;
            end
        end
    end

    upsz_out_slice #(.PW($bits(out_t))) u_slice (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s_valid),
        .in_ready  (s_ready),
        .in_data   (nxt),
        .out_valid (m_valid),
        .out_ready (m_ready),
        .out_data  (q)
    );

    assign m_addr      = q.addr;
    assign m_len       = q.ctl.len;
    assign m_size      = q.ctl.size;
    assign m_burst     = q.ctl.burst;
    assign m_lock      = q.ctl.lock;
    assign m_cache     = q.ctl.cache;
    assign m_packed    = q.pk;
    assign m_orig_size = q.osize;
    assign m_low_addr  = q.low;

    // R1: an unpacked result keeps the requested size
    assert_passthru_size_R1: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_packed |-> m_size == m_orig_size);

    // R2: FIXED input never yields a packed result
    assert_fixed_unpacked_R2: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready && (s_burst == BT_FIXED) |=> !m_packed);

    // R4: a packed result always uses the full master width
    assert_packed_size_R4: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_packed |-> m_size == SIZE_W'(MLOG));

    // R5: a packed WRAP result never has length zero
    assert_wrap_len_R5: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_packed && (m_burst == BT_WRAP) |-> m_len != '0);

    // R8: lock follows the accepted input
    assert_lock_copy_R8: assert property (@(posedge clk) disable iff (rst)
        s_valid && s_ready |=> m_lock == $past(s_lock));
endmodule

// File: tb/sim_upsz_cmd_xlate.sv
`timescale 1ns/1ps
module sim_upsz_cmd_xlate;
    localparam int AW   = 32;
    localparam int MB   = 16;
    localparam int MLOG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          s_valid = 1'b0;
    logic [AW-1:0] s_addr  = '0;
    logic [7:0]    s_len   = '0;
    logic [2:0]    s_size  = '0;
    logic [1:0]    s_burst = '0;
    logic          s_lock  = 1'b0;
    logic [3:0]    s_cache = '0;
    logic          m_ready = 1'b1;

    logic          s_ready   [3];
    logic          m_valid   [3];
    logic [AW-1:0] m_addr    [3];
    logic [7:0]    m_len     [3];
    logic [2:0]    m_size    [3];
    logic [1:0]    m_burst   [3];
    logic          m_lock    [3];
    logic [3:0]    m_cache   [3];
    logic          m_packed  [3];
    logic [2:0]    m_osize   [3];
    logic [MLOG-1:0] m_low   [3];

    upsz_cmd_xlate #(.S_DW(32), .M_DW(128), .AW(AW), .IS_WRITE(1), .LITE(0)) u0 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready[0]),
        .s_addr(s_addr), .s_len(s_len), .s_size(s_size), .s_burst(s_burst),
        .s_lock(s_lock), .s_cache(s_cache), .m_valid(m_valid[0]), .m_ready(m_ready),
        .m_addr(m_addr[0]), .m_len(m_len[0]), .m_size(m_size[0]), .m_burst(m_burst[0]),
        .m_lock(m_lock[0]), .m_cache(m_cache[0]), .m_packed(m_packed[0]),
        .m_orig_size(m_osize[0]), .m_low_addr(m_low[0]));

    upsz_cmd_xlate #(.S_DW(32), .M_DW(128), .AW(AW), .IS_WRITE(0), .LITE(0)) u1 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready[1]),
        .s_addr(s_addr), .s_len(s_len), .s_size(s_size), .s_burst(s_burst),
        .s_lock(s_lock), .s_cache(s_cache), .m_valid(m_valid[1]), .m_ready(m_ready),
        .m_addr(m_addr[1]), .m_len(m_len[1]), .m_size(m_size[1]), .m_burst(m_burst[1]),
        .m_lock(m_lock[1]), .m_cache(m_cache[1]), .m_packed(m_packed[1]),
        .m_orig_size(m_osize[1]), .m_low_addr(m_low[1]));

    upsz_cmd_xlate #(.S_DW(32), .M_DW(128), .AW(AW), .IS_WRITE(1), .LITE(1)) u2 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready[2]),
        .s_addr(s_addr), .s_len(s_len), .s_size(s_size), .s_burst(s_burst),
        .s_lock(s_lock), .s_cache(s_cache), .m_valid(m_valid[2]), .m_ready(m_ready),
        .m_addr(m_addr[2]), .m_len(m_len[2]), .m_size(m_size[2]), .m_burst(m_burst[2]),
        .m_lock(m_lock[2]), .m_cache(m_cache[2]), .m_packed(m_packed[2]),
        .m_orig_size(m_osize[2]), .m_low_addr(m_low[2]));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        longint addr;
        int len, size, burst, lock, cache, pk, osize, low;
        string tag;
    } ex_t;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic ex_t model(input int wr, input int lite, input longint a, input int len,
                                  input int size, input int burst, input int cache, input int lock);
        ex_t e;
        longint sb, st, en, bb, base, off, so;
        e.addr = a; e.len = len; e.size = size; e.burst = burst; e.lock = lock;
        e.cache = cache; e.pk = 0; e.osize = size; e.low = int'(a % MB);
        if (lite != 0)                       e.tag = "R3";
        else if (burst == 0 || burst == 3)   e.tag = "R2";
        else if ((cache & 2) == 0)           e.tag = "R1";
        else begin
            e.pk = 1;
            e.size = MLOG;
            sb = longint'(1) << size;
            if (burst == 1) begin
                e.tag = "R4";
                st = (a / MB) * MB;
                en = (((a / sb) * sb + len * sb) / MB) * MB;
                e.len = int'((en - st) / MB);
            end else begin
                e.tag = (wr != 0) ? "R5_R6" : "R5_R7";
                bb = (len + 1) * sb;
                e.len = int'((bb + MB - 1) / MB - 1);
                base = (a / bb) * bb;
                off = a - base;
                if (wr != 0) so = (((off + MB - 1) / MB) * MB) % bb;
                else         so = (off / MB) * MB;
                e.addr = base + so;
                e.burst = (e.len > 0) ? 2 : 1;
            end
        end
        return e;
    endfunction

    task automatic check_inst(input int i, input ex_t e);
        chk(e.tag, "addr", longint'(m_addr[i]), e.addr);
        chk(e.tag, "len", longint'(m_len[i]), longint'(e.len));
        chk(e.tag, "size", longint'(m_size[i]), longint'(e.size));
        chk(e.tag, "burst", longint'(m_burst[i]), longint'(e.burst));
        chk(e.tag, "cache", longint'(m_cache[i]), longint'(e.cache));
        chk("R8", "lock", longint'(m_lock[i]), longint'(e.lock));
        chk("R9", "packed", longint'(m_packed[i]), longint'(e.pk));
        chk("R9", "orig_size", longint'(m_osize[i]), longint'(e.osize));
        chk("R9", "low_addr", longint'(m_low[i]), longint'(e.low));
        chk("R10", "m_valid", longint'(m_valid[i]), 1);
    endtask

    task automatic run_one(input longint a, input int len, input int size, input int burst,
                           input int cache, input int lock);
        @(negedge clk);
        s_valid = 1'b1; s_addr = AW'(a); s_len = 8'(len); s_size = 3'(size);
        s_burst = 2'(burst); s_cache = 4'(cache); s_lock = lock[0];
        @(negedge clk);
        s_valid = 1'b0;
        check_inst(0, model(1, 0, a, len, size, burst, cache, lock));
        check_inst(1, model(0, 0, a, len, size, burst, cache, lock));
        check_inst(2, model(1, 1, a, len, size, burst, cache, lock));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int wl [4];
        int il [6];
        int cv [2];
        ex_t ea, eb;
        wl = '{1, 3, 7, 15};
        il = '{0, 1, 2, 5, 15, 255};
        cv = '{2, 13};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset m_valid", longint'(m_valid[0]), 0);
        chk("R10", "reset s_ready", longint'(s_ready[0]), 1);
        rst = 1'b0;

        for (int sz = 0; sz < 3; sz++)
            for (int ad = 0; ad < 64; ad++)
                for (int bt = 0; bt < 4; bt++)
                    for (int c = 0; c < 2; c++) begin
                        if (bt == 2) begin
                            for (int k = 0; k < 4; k++)
                                run_one(longint'(32'h100 + ((ad >> sz) << sz)), wl[k], sz, bt,
                                        cv[c], (ad + k) & 1);
                        end else begin
                            for (int k = 0; k < 6; k++)
                                run_one(longint'(32'h100 + ad), il[k], sz, bt, cv[c], (ad + k) & 1);
                        end
                    end

        // R10: stall with a second command waiting
        @(negedge clk);
        m_ready = 1'b0;
        s_valid = 1'b1; s_addr = 32'h214; s_len = 8'd7; s_size = 3'd2;
        s_burst = 2'd2; s_cache = 4'd2; s_lock = 1'b1;
        ea = model(1, 0, 64'h214, 7, 2, 2, 2, 1);
        @(negedge clk);
        check_inst(0, ea);
        chk("R10", "s_ready while full", longint'(s_ready[0]), 0);
        s_addr = 32'h333; s_len = 8'd4; s_size = 3'd1; s_burst = 2'd1; s_lock = 1'b0;
        eb = model(1, 0, 64'h333, 4, 1, 1, 2, 0);
        @(negedge clk);
        check_inst(0, ea);
        chk("R10", "s_ready still full", longint'(s_ready[0]), 0);
        m_ready = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        check_inst(0, eb);
        @(negedge clk);
        chk("R10", "drained m_valid", longint'(m_valid[0]), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule